// File: doc/BRIEF.md
# Inverse-Transform Scale and Carry Unit

This block closes out a number-theoretic inverse transform used for very large integer multiplication. The transform leaves one 64-bit residue modulo p = 2^64 - 2^32 + 1 per coefficient. The block accepts these residues as a stream, one per clock, least significant coefficient first. It multiplies each residue by the inverse of the transform length modulo p and adds the carry left by the previous coefficient. It then splits the reduced sum into a 24-bit output digit and a 40-bit carry for the next coefficient. The result is the product in radix 2^24, streamed out while the residues are still arriving.

The scaling constant is 0xFFFF555455560001, which is congruent to -(2^17 · 0x55555555) modulo p. That form lets the multiply be built from four shift-and-add levels and one modular reduction, with no general multiplier. The multiply runs in a two-register pipeline ahead of the carry stage. Only the modular add of the carry sits in the one-cycle feedback loop. Once the configured number of residues has been taken in, the leftover carry is emitted as extra 24-bit digits, lowest first, until it is zero. A one-cycle done pulse then marks the end of the stream.

Top module: `iscale_carry`

## Requirements
- R1: For each accepted residue d, with running carry c (zero for the first residue after start), the block forms t = (d · 0xFFFF555455560001 + c) mod p, with p = 0xFFFFFFFF00000001. It emits t[23:0] as the output digit and keeps t[63:24] as the carry for the next residue.
- R2: Residues are accepted only while a stream is running. One is taken on each rising edge at which in_valid is high, up to NUM_DIGITS residues per stream. Gaps in in_valid are allowed, and digits leave in the order their residues arrived.
- R3: The output digit for a residue is valid (out_valid high) just after the third rising edge that follows the edge accepting that residue.
- R4: in_valid is ignored while no stream is running: before start, and after NUM_DIGITS residues have been accepted. No output digit results from such cycles.
- R5: After the digit for the last residue, the remaining carry leaves as additional 24-bit digits, low bits first, one per cycle, until it is zero. A zero carry adds no digit.
- R6: After reset, out_valid and done are low. done is high for exactly one cycle, in the cycle right after the final digit of a stream, and never together with out_valid.
- R7: A start pulse while a stream is in progress is ignored. The stream's digits are unchanged by it.
- R8: Residue inputs at or above p are treated as their value modulo p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a stream and clears the carry when idle |
| in_valid | input | 1 | Residue on in_res is offered this cycle |
| in_res | input | 64 | Residue from the inverse transform |
| out_valid | output | 1 | out_digit holds a result digit |
| out_digit | output | 24 | Result digit in radix 2^24 |
| done | output | 1 | One-cycle pulse after the last digit of a stream |

## Verification
The bench builds the block with NUM_DIGITS set to 6, so that a whole stream fits in a few dozen cycles. At that length, every stream reaches the end-of-stream carry flush, the return to idle and the done pulse. Restarts, inputs offered after the sixth residue, and start pulses in mid-stream can then be tried across seven scenarios. The scaling constant and the 64-bit datapath are the same as at full length. Extreme residues such as p-1 and values above p therefore drive the full 40-bit carry and the two-digit flush exactly as a full-size stream would.

// File: rtl/iscale_pkg.sv
`timescale 1ns/1ps
package iscale_pkg;

  localparam int RES_W = 64;
  localparam logic [63:0] MOD_P = 64'hFFFFFFFF00000001;
  // 2^64 mod p
  localparam logic [63:0] WRAP = 64'h00000000FFFFFFFF;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_TAIL} phase_e;

  // Fold a value below 2^67 into [0, p).
  function automatic logic [63:0] fold67(input logic [66:0] v);
    logic [66:0] w;
    logic [63:0] r;
    w = 67'(v[63:0]) + 67'(v[66:64]) * 67'(WRAP);
    w = 67'(w[63:0]) + 67'(w[66:64]) * 67'(WRAP);
    r = w[63:0];
    if (r >= MOD_P) r = r - MOD_P;
    return r;
  endfunction

  // 128-bit value mod p, using 2^64 = 2^32 - 1 and 2^96 = -1.
  function automatic logic [63:0] red128(input logic [127:0] z);
    logic [66:0] v;
    v = (67'(z[95:64]) + 67'(z[63:32])) << 32;
    v = v + 67'(z[31:0]) + (67'(MOD_P) << 1) - 67'(z[127:96]) - 67'(z[95:64]);
    return fold67(v);
  endfunction

  function automatic logic [63:0] neg_mod(input logic [63:0] x);
    return (x == 64'd0) ? 64'd0 : MOD_P - x;
  endfunction

  // a < p, b < 2^40: one conditional subtract is enough.
  function automatic logic [63:0] add_mod(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] s;
    s = 65'(a) + 65'(b);
    if (s >= 65'(MOD_P)) s = s - 65'(MOD_P);
    return s[63:0];
  endfunction

endpackage

// File: rtl/iscale_mulconst.sv
`timescale 1ns/1ps
// Two-stage multiply by the inverse transform length mod p.
// The constant equals -(2^17 * 0x55555555) mod p, and
// 0x55555555 = 5 * 0x11 * 0x101 * 0x10001, so each level is x + (x << 2^(k+1)).
module iscale_mulconst
  import iscale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_valid,
  input  logic             d_last,
  input  logic [RES_W-1:0] d_val,
  output logic             m_valid,
  output logic             m_last,
  output logic [RES_W-1:0] m_val
);
  localparam int NLEV    = 4;
  localparam int UW      = RES_W + 32;
  localparam int POST_SH = 17;

  logic [UW-1:0] lvl [NLEV+1];
  assign lvl[0] = UW'(d_val);

  for (genvar k = 0; k < NLEV; k++) begin : g_lvl
    assign lvl[k+1] = lvl[k] + (lvl[k] << (2 << k));
  end

  logic          a_valid, a_last;
  logic [UW-1:0] a_u;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_last  <= 1'b0;
      a_u     <= '0;
    end else begin
      a_valid <= d_valid;
      a_last  <= d_valid & d_last;
      a_u     <= lvl[NLEV];
    end
  end

  logic [127:0]     z_wide;
  logic [RES_W-1:0] scaled;
  assign z_wide = 128'(a_u) << POST_SH;
  assign scaled = neg_mod(red128(z_wide));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_last  <= 1'b0;
      m_val   <= '0;
    end else begin
      m_valid <= a_valid;
      m_last  <= a_valid & a_last;
      m_val   <= scaled;
    end
  end
endmodule

// File: rtl/iscale_carry_loop.sv
`timescale 1ns/1ps
// Single-cycle carry feedback: modular add, split into digit and carry,
// then flush the carry after the final residue.
module iscale_carry_loop
  import iscale_pkg::*;
#(
  parameter int DIG_W = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   m_valid,
  input  logic                   m_last,
  input  logic [RES_W-1:0]       m_val,
  output logic                   o_valid,
  output logic [DIG_W-1:0]       o_digit,
  output logic                   o_done,
  output logic [RES_W-DIG_W-1:0] carry_q,
  output logic                   flush_emit
);
  localparam int CARRY_W = RES_W - DIG_W;

  logic             flushing;
  logic [RES_W-1:0] sum;

  assign sum        = add_mod(m_val, RES_W'(carry_q));
  assign flush_emit = flushing & (carry_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q  <= '0;
      flushing <= 1'b0;
      o_valid  <= 1'b0;
      o_digit  <= '0;
      o_done   <= 1'b0;
    end else begin
      o_valid <= 1'b0;
      o_done  <= 1'b0;
      if (clear) begin
        carry_q  <= '0;
        flushing <= 1'b0;
      end else if (m_valid) begin
        o_valid  <= 1'b1;
        o_digit  <= sum[DIG_W-1:0];
        carry_q  <= sum[RES_W-1:DIG_W];
        flushing <= m_last;
      end else if (flush_emit) begin
        o_valid <= 1'b1;
        o_digit <= carry_q[DIG_W-1:0];
        carry_q <= CARRY_W'(carry_q >> DIG_W);
      end else if (flushing) begin
        o_done   <= 1'b1;
        flushing <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iscale_carry.sv
`timescale 1ns/1ps
module iscale_carry
  import iscale_pkg::*;
#(
  parameter int NUM_DIGITS = 98304,
  parameter int DIG_W      = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic [63:0]      in_res,
  output logic             out_valid,
  output logic [DIG_W-1:0] out_digit,
  output logic             done
);
  localparam int CARRY_W = RES_W - DIG_W;
  localparam int CNT_W   = $clog2(NUM_DIGITS + 1);

  phase_e             phase;
  logic [CNT_W-1:0]   in_cnt;
  logic               start_ok, accept, last_in;
  logic               s1_valid, s1_last;
  logic [RES_W-1:0]   s1_res;
  logic               m_valid, m_last;
  logic [RES_W-1:0]   m_val;
  logic [CARRY_W-1:0] carry_q;
  logic               flush_emit;

  assign start_ok = start & (phase == PH_IDLE);
  assign accept   = in_valid & (phase == PH_RUN);
  assign last_in  = (in_cnt == CNT_W'(NUM_DIGITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      in_cnt   <= '0;
      s1_valid <= 1'b0;
      s1_last  <= 1'b0;
      s1_res   <= '0;
    end else begin
      s1_valid <= accept;
      s1_last  <= accept & last_in;
      if (accept) s1_res <= in_res;
      case (phase)
        PH_IDLE: if (start_ok) begin
          phase  <= PH_RUN;
          in_cnt <= '0;
        end
        PH_RUN: if (accept) begin
          in_cnt <= in_cnt + 1'b1;
          if (last_in) phase <= PH_TAIL;
        end
        default: if (done) phase <= PH_IDLE;
      endcase
    end
  end

  iscale_mulconst u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (s1_valid),
    .d_last  (s1_last),
    .d_val   (s1_res),
    .m_valid (m_valid),
    .m_last  (m_last),
    .m_val   (m_val)
  );

  iscale_carry_loop #(.DIG_W(DIG_W)) u_loop (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ok),
    .m_valid    (m_valid),
    .m_last     (m_last),
    .m_val      (m_val),
    .o_valid    (out_valid),
    .o_digit    (out_digit),
    .o_done     (done),
    .carry_q    (carry_q),
    .flush_emit (flush_emit)
  );
endmodule

// File: rtl/iscale_chk.sv
`timescale 1ns/1ps
module iscale_chk #(
  parameter int CW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          start_ok,
  input logic          out_valid,
  input logic          done,
  input logic          flush_emit,
  input logic [CW-1:0] carry_q
);
  // R1: a new stream begins with a zero carry
  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (carry_q == '0));

  // R3: every accepted residue gives a digit three edges later
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept, 4) |-> out_valid);

  // R5: a 40-bit carry needs at most two flush digits
  p_flush_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush_emit) && flush_emit) |=> !flush_emit);

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: done never coincides with a digit
  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

bind iscale_carry iscale_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .start_ok   (start_ok),
  .out_valid  (out_valid),
  .done       (done),
  .flush_emit (flush_emit),
  .carry_q    (carry_q)
);

// File: tb/test_iscale_carry.sv
`timescale 1ns/1ps
module test_iscale_carry;
  localparam int ND = 6;
  localparam logic [63:0] P     = 64'hFFFFFFFF00000001;
  localparam logic [63:0] SCALE = 64'hFFFF555455560001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_res = '0;
  logic        out_valid;
  logic [23:0] out_digit;
  logic        done;

  always #10 clk = ~clk;

  iscale_carry #(.NUM_DIGITS(ND)) i_iscale_carry (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_res(in_res), .out_valid(out_valid), .out_digit(out_digit), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [23:0] got_d   [256];
  int          got_cyc [256];
  int          n_got = 0;
  int          done_cnt = 0;
  int          done_cyc = 0;
  int          overlap = 0;

  always @(negedge clk) begin
    if (out_valid && n_got < 256) begin
      got_d[n_got]   <= out_digit;
      got_cyc[n_got] <= cyc;
      n_got          <= n_got + 1;
    end
    if (done) begin
      done_cnt <= done_cnt + 1;
      done_cyc <= cyc;
    end
    if (done && out_valid) overlap <= overlap + 1;
  end

  logic [23:0] exp_d [16];
  int          n_exp;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // Reference: scale, add carry, split; then drain the carry (R1, R5).
  task automatic build_exp(input logic [63:0] v [ND]);
    logic [63:0] c;
    c = '0;
    n_exp = 0;
    for (int i = 0; i < ND; i++) begin
      logic [127:0] pr;
      logic [64:0]  s;
      pr = 128'(v[i]) * 128'(SCALE);
      s  = 65'(pr % 128'(P)) + 65'(c);
      s  = s % 65'(P);
      exp_d[n_exp] = s[23:0];
      n_exp++;
      c = 64'(s[63:24]);
    end
    while (c != 0) begin
      exp_d[n_exp] = c[23:0];
      n_exp++;
      c = c >> 24;
    end
  endtask

  task automatic run_case(input string rq, input logic [63:0] v [ND],
                          input logic [63:0] ref_v [ND], input int gap,
                          input bit junk, input int start_at);
    int b, dc, first_drv, t;
    b  = n_got;
    dc = done_cnt;
    build_exp(ref_v);
    if (junk) begin
      for (int j = 0; j < 3; j++) begin
        in_valid = 1'b1; in_res = 64'hDEAD_0000_0000_0000 + 64'(j);
        @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (5) @(negedge clk);
      chk(n_got == b, "R4", "digits from in_valid before start", n_got - b, 0);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    first_drv = 0;
    for (int i = 0; i < ND; i++) begin
      in_valid = 1'b1;
      in_res   = v[i];
      start    = (i == start_at);
      if (i == 0) first_drv = cyc;
      @(negedge clk);
      in_valid = 1'b0;
      start    = 1'b0;
      repeat (gap) @(negedge clk);
    end
    if (junk) begin
      for (int j = 0; j < 3; j++) begin
        in_valid = 1'b1; in_res = 64'h1234_5678_0000_0000 + 64'(j);
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    t = 0;
    while (done_cnt == dc && t < 100) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(n_got - b == n_exp, rq, "digit count", n_got - b, n_exp);
    for (int i = 0; i < n_exp && i < n_got - b; i++)
      chk(got_d[b+i] == exp_d[i], rq, $sformatf("digit %0d", i), got_d[b+i], exp_d[i]);
    chk(got_cyc[b] - first_drv == 4, "R3", "first digit latency", got_cyc[b] - first_drv, 4);
    chk(done_cnt - dc == 1, "R6", "done pulses", done_cnt - dc, 1);
    chk(done_cyc == got_cyc[n_got-1] + 1, "R6", "done cycle", done_cyc, got_cyc[n_got-1] + 1);
  endtask

  task automatic test_reset;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R6", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R6", "outputs after reset",
        {out_valid, done}, 0);
  endtask

  task automatic test_small; // R1, R5
    logic [63:0] v [ND] = '{64'd1, 64'd2, 64'd3, 64'd4, 64'd5, 64'd6};
    run_case("R1", v, v, 0, 1'b0, -1);
  endtask

  task automatic test_large; // R5 with a wide final carry
    logic [63:0] v [ND] = '{P - 1, P - 2, 64'h123456789ABCDEF0, P - 1,
                            64'hFFFFFFFF00000000, 64'd7};
    run_case("R5", v, v, 0, 1'b0, -1);
  endtask

  task automatic test_zero; // R5: zero carry adds no digit
    logic [63:0] v [ND] = '{default: 64'd0};
    run_case("R5", v, v, 0, 1'b0, -1);
    chk(n_exp == ND, "R5", "reference flush length", n_exp, ND);
  endtask

  task automatic test_gaps; // R2, R4
    logic [63:0] v [ND] = '{64'h0000_0001_0000_0000, 64'hFFFF_0000_FFFF_0000,
                            64'd99, 64'h8000_0000_0000_0000, 64'd0, P - 5};
    run_case("R2", v, v, 2, 1'b1, -1);
  endtask

  task automatic test_restart_busy; // R7
    logic [63:0] v [ND] = '{64'hAAAA_BBBB_CCCC_DDDD, P - 1, 64'd12345,
                            64'h0F0F_0F0F_0F0F_0F0F, P - 7, 64'd1};
    run_case("R7", v, v, 1, 1'b0, 3);
  endtask

  task automatic test_noncanon; // R8
    logic [63:0] v [ND];
    logic [63:0] r [ND];
    for (int i = 0; i < ND; i++) begin
      r[i] = 64'h0000_0000_1111_0000 * 64'(i + 1) + 64'd3;
      v[i] = P + r[i];
    end
    run_case("R8", v, r, 0, 1'b0, -1);
  endtask

  initial begin
    test_reset();
    test_small();
    test_large();
    test_zero();
    test_gaps();
    test_restart_busy();
    test_noncanon();
    chk(overlap == 0, "R6", "done with digit", overlap, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule